// File: doc/BRIEF.md
# SPI Master Word Serializer

This block is the shifting core of a SPI master. A single 32-bit control word sets the serial clock mode (idle level and sampling edge), an internal loopback path, the word length and a two-stage serial clock divider. Transmit words come from the read side of a show-ahead transmit FIFO. Each finished word goes to the write side of a receive FIFO. The block drives the serial clock, the data output and one active-low chip select, and it samples the serial data input.

When `enable` is high and the transmit FIFO holds data, the engine takes one word and shifts it out MSB first. At the same time it shifts one word in. It keeps the chip select low across back-to-back words and releases it once the FIFO has run dry. The control word is captured at the start of every word, so software may rewrite it while a word is in flight.

Top module: `spi_word_engine`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1, `busy` is 0, `sclk` is 0 and `rx_push` is 0.
- R2: Control word fields: bit 1 is loopback, bit 2 is clock idle level, bit 3 is the phase select, bits 11:4 are the prescaler, bits 19:12 are the post-divider and bits 24:20 are the word length minus one. Bit 0, bit 25 and bits 31:26 have no effect.
- R3: Each half period of `sclk` lasts (prescaler/2)×(post+1) clock cycles, so a full period is (post+1)×prescaler cycles. The first `sclk` edge of a word appears one half period plus one cycle after the `tx_pop` cycle.
- R4: A prescaler field of 0 or 1 acts as 2. An odd value acts as the next even value, except that 255 acts as 254.
- R5: A word has (length field + 1) bits, and a field below 3 gives 4 bits. Each word makes exactly twice that many `sclk` edges and leaves `sclk` at its idle level.
- R6: `mosi` carries the low N bits of the popped `tx_data`, MSB first, and changes only on `sclk` edges or at a word load.
- R7: When idle, `sclk` sits at the level of bit 2. With bit 3 clear, input is sampled on the 1st, 3rd, … edges and `mosi` moves on the others. With bit 3 set, input is sampled on the 2nd, 4th, … edges.
- R8: Each word gives exactly one single-cycle `rx_push`, in the cycle where its final `sclk` edge appears. `rx_data` then holds the received bits right-aligned and zero-extended.
- R9: With loopback set, the receive path samples `mosi` and ignores `miso`.
- R10: A word starts only while `enable` is 1 and `tx_empty` is 0. `tx_pop` is a one-cycle pulse per word. With `enable` low, nothing is popped and `cs_n` stays high.
- R11: `cs_n` goes low with the first word of a burst and stays low between back-to-back words. It rises one cycle after the last `rx_push` when no word is waiting.
- R12: `busy` is 1 exactly while `cs_n` is 0.
- R13: A control word change during a word does not affect that word's timing, mode or loopback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new words to start |
| ctrl | input | 32 | Control word |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 32 | Head word of transmit FIFO (show-ahead) |
| tx_pop | output | 1 | Consume the head transmit word |
| rx_data | output | 32 | Received word, valid with `rx_push` |
| rx_push | output | 1 | Write `rx_data` to the receive FIFO |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A transfer is in progress |

## Verification
The first `sclk` edge of a word is due H+1 cycles after the cycle in which `tx_pop` is seen, where H is the half period. Every later edge within the word is due H cycles after the previous one. `rx_push` is due in the same cycle as the final edge, and `cs_n` must rise in the cycle after that. The bench samples all outputs at the falling clock edge and records the cycle number of each event. It then compares these cycle differences with the expected values for each vector, so an edge that is early or late by a single cycle is caught.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   // control word geometry; positions are decoded by the register block
   localparam int CTRL_W   = 32;
   localparam int LOOP_BIT = 1;
   localparam int CPOL_BIT = 2;
   localparam int CPHA_BIT = 3;
   localparam int PRE_LSB  = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } eng_state_t;
endpackage

// File: rtl/spi_eng_clkdiv.sv
// Two-stage divider: prescaler half count, then post count, gives one
// serial clock edge request per half period.
module spi_eng_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] pre_even,
   input  logic [DIV_W-1:0] post,
   output logic             edge_o
);
   localparam int HALF_W = DIV_W - 1;

   logic [HALF_W-1:0] pcnt;
   logic [DIV_W-1:0]  qcnt;
   logic [HALF_W-1:0] half;
   logic              tick;

   assign half   = pre_even[DIV_W-1:1];
   assign tick   = run && (pcnt == half - 1'b1);
   assign edge_o = tick && (qcnt == post);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pcnt <= '0;
         qcnt <= '0;
      end else if (tick) begin
         pcnt <= '0;
         qcnt <= (qcnt == post) ? '0 : qcnt + 1'b1;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/spi_eng_shifter.sv
// Shift pair: left-aligned transmit register and right-growing receive register.
module spi_eng_shifter #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic              edge_i,
   input  logic              cpha,
   input  logic              din,
   input  logic [CNT_W-1:0]  last_edge,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_word,
   output logic              done_o
);
   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [CNT_W-1:0]  ec;
   logic              sample;
   logic              shift;

   assign sample  = edge_i && (ec[0] == cpha);
   assign shift   = edge_i && (ec[0] != cpha) && (ec != '0);
   assign done_o  = edge_i && (ec == last_edge);
   assign mosi    = tx_sr[DATA_W-1];
   assign rx_word = rx_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
         ec    <= '0;
      end else if (load) begin
         tx_sr <= load_word;
         rx_sr <= '0;
         ec    <= '0;
      end else if (edge_i) begin
         ec <= ec + 1'b1;
         if (shift)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         if (sample) rx_sr <= {rx_sr[DATA_W-2:0], din};
      end
   end
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
   parameter int DATA_W   = 32,
   parameter int DIV_W    = 8,
   parameter int MIN_BITS = 4,
   parameter bit HAS_LOOP = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          enable,
   input  logic [spi_eng_pkg::CTRL_W-1:0] ctrl,
   input  logic                          tx_empty,
   input  logic [DATA_W-1:0]             tx_data,
   output logic                          tx_pop,
   output logic [DATA_W-1:0]             rx_data,
   output logic                          rx_push,
   output logic                          sclk,
   output logic                          mosi,
   output logic                          cs_n,
   input  logic                          miso,
   output logic                          busy
);
   import spi_eng_pkg::*;

   localparam int LEN_W    = $clog2(DATA_W);
   localparam int CNT_W    = LEN_W + 1;
   localparam int POST_LSB = PRE_LSB + DIV_W;
   localparam int LEN_LSB  = POST_LSB + DIV_W;

   generate
      if (DATA_W < MIN_BITS || (1 << LEN_W) != DATA_W)
         $error("DATA_W must be a power of two not below MIN_BITS");
      if (MIN_BITS < 2)
         $error("MIN_BITS must be at least 2");
      if (DIV_W < 2 || LEN_LSB + LEN_W > CTRL_W)
         $error("control fields do not fit the control word");
   endgenerate

   typedef struct packed {
      logic             loop;
      logic             cpol;
      logic             cpha;
      logic [DIV_W-1:0] pre;
      logic [DIV_W-1:0] post;
      logic [LEN_W-1:0] nbm1;
   } cfg_t;

   function automatic logic [DIV_W-1:0] even_pre(input logic [DIV_W-1:0] p);
      if (p < DIV_W'(2))  return DIV_W'(2);
      else if (&p)        return p - 1'b1;
      else if (p[0])      return p + 1'b1;
      else                return p;
   endfunction

   cfg_t             dec;
   cfg_t             cfg_q;
   eng_state_t       state;
   logic             start;
   logic             sclk_edge;
   logic             word_done;
   logic             din;
   logic             sclk_q;
   logic             cs_q;
   logic [LEN_W-1:0] len_raw;

   always_comb begin
      len_raw  = ctrl[LEN_LSB +: LEN_W];
      dec.loop = ctrl[LOOP_BIT];
      dec.cpol = ctrl[CPOL_BIT];
      dec.cpha = ctrl[CPHA_BIT];
      dec.pre  = even_pre(ctrl[PRE_LSB +: DIV_W]);
      dec.post = ctrl[POST_LSB +: DIV_W];
      dec.nbm1 = (len_raw < LEN_W'(MIN_BITS - 1)) ? LEN_W'(MIN_BITS - 1) : len_raw;
   end

   assign start   = rst_n && enable && !tx_empty && (state != ST_SHIFT);
   assign tx_pop  = start;
   assign rx_push = (state == ST_GAP);
   assign busy    = (state != ST_IDLE);
   assign sclk    = sclk_q;
   assign cs_n    = cs_q;

   generate
      if (HAS_LOOP) begin : g_loop
         assign din = cfg_q.loop ? mosi : miso;
      end else begin : g_noloop
         assign din = miso;
      end
   endgenerate

   spi_eng_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state == ST_SHIFT),
      .pre_even (cfg_q.pre),
      .post     (cfg_q.post),
      .edge_o   (sclk_edge)
   );

   spi_eng_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_word (tx_data << (LEN_W'(DATA_W - 1) - dec.nbm1)),
      .edge_i    (sclk_edge),
      .cpha      (cfg_q.cpha),
      .din       (din),
      .last_edge ({cfg_q.nbm1, 1'b1}),
      .mosi      (mosi),
      .rx_word   (rx_data),
      .done_o    (word_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cfg_q  <= '0;
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         if (state != ST_SHIFT) begin
            cfg_q  <= dec;
            sclk_q <= dec.cpol;
         end else if (sclk_edge) begin
            sclk_q <= ~sclk_q;
         end
         unique case (state)
            ST_IDLE:  if (start) begin
                         state <= ST_SHIFT;
                         cs_q  <= 1'b0;
                      end
            ST_SHIFT: if (word_done) state <= ST_GAP;
            ST_GAP:   if (start) state <= ST_SHIFT;
                      else begin
                         state <= ST_IDLE;
                         cs_q  <= 1'b1;
                      end
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] ctrl,
   input logic        tx_pop,
   input logic        rx_push,
   input logic        sclk,
   input logic        mosi,
   input logic        cs_n,
   input logic        busy
);
   // R12
   busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !cs_n);

   // R10
   pop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> busy);

   // R8
   push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push);

   // R7
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $past(rst_n)) |-> (sclk == $past(ctrl[2])));

   // R6
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && $stable(sclk) && !$past(tx_pop)) |-> $stable(mosi));
endmodule

bind spi_word_engine spi_eng_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ctrl    (ctrl),
   .tx_pop  (tx_pop),
   .rx_push (rx_push),
   .sclk    (sclk),
   .mosi    (mosi),
   .cs_n    (cs_n),
   .busy    (busy)
);

// File: tb/tb_spi_word_engine.sv
module tb_spi_word_engine;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic        cpol;
      logic        cpha;
      logic        loop;
      logic [7:0]  pre;
      logic [7:0]  post;
      logic [4:0]  lm1;
      logic [31:0] tx;
      logic [31:0] mi;
      logic [7:0]  h;
      logic [5:0]  bits;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 1'b0, 8'd2,   8'd0, 5'd7,  32'h0000_00A5, 32'h0000_003C, 8'd1,   6'd8},
      '{1'b1, 1'b0, 1'b0, 8'd4,   8'd1, 5'd15, 32'h1234_BEEF, 32'hFFFF_8001, 8'd4,   6'd16},
      '{1'b0, 1'b1, 1'b1, 8'd6,   8'd0, 5'd11, 32'h0000_0ABC, 32'h0000_0555, 8'd3,   6'd12},
      '{1'b1, 1'b1, 1'b0, 8'd2,   8'd2, 5'd31, 32'hDEAD_BEEF, 32'hC0FF_EE11, 8'd3,   6'd32},
      '{1'b0, 1'b1, 1'b0, 8'd5,   8'd0, 5'd1,  32'h0000_00F9, 32'h0000_00A6, 8'd3,   6'd4},
      '{1'b1, 1'b0, 1'b1, 8'd0,   8'd1, 5'd4,  32'h0000_0013, 32'h0000_001F, 8'd2,   6'd5},
      '{1'b0, 1'b0, 1'b0, 8'd255, 8'd0, 5'd3,  32'h0000_0006, 32'h0000_0009, 8'd127, 6'd4},
      '{1'b1, 1'b1, 1'b0, 8'd1,   8'd3, 5'd9,  32'h0000_02C3, 32'h0000_0135, 8'd4,   6'd10}
   };

   logic        clk, rst_n, enable, tx_empty, tx_pop, rx_push;
   logic        sclk, mosi, cs_n, miso, busy;
   logic [31:0] ctrl, tx_data, rx_data;

   logic [31:0] txq [8];
   int          wr_n, rd_n;
   int          n_err, n_chk;

   // stimulus-owned monitor settings
   int          word_id, exp_h, nbits, cpha_m;
   logic [31:0] miso_pat;

   // monitor-owned records
   int          seen_id, cyc, edge_n, samp_n, bad_iv, last_edge_cyc, first_cyc;
   int          pop_cyc, push_cyc, cs_rise_cyc, push_n, pop_n, cs_rise_n;
   logic [31:0] mosi_cap, rx_last;
   logic        prev_sclk, prev_cs;

   assign tx_empty = (rd_n == wr_n);
   assign tx_data  = txq[rd_n % 8];
   assign miso     = (samp_n < nbits) ? miso_pat[nbits - 1 - samp_n] : 1'b0;

   spi_word_engine dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl(ctrl),
      .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_data(rx_data), .rx_push(rx_push), .sclk(sclk), .mosi(mosi),
      .cs_n(cs_n), .miso(miso), .busy(busy)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_P / 2) clk = ~clk;
   end

   initial rd_n = 0;
   always @(posedge clk) if (tx_pop) rd_n <= rd_n + 1;

   initial begin
      seen_id = 0; cyc = 0; edge_n = 0; samp_n = 0; bad_iv = 0;
      last_edge_cyc = 0; first_cyc = 0; pop_cyc = 0; push_cyc = 0;
      cs_rise_cyc = 0; push_n = 0; pop_n = 0; cs_rise_n = 0;
      mosi_cap = '0; rx_last = '0; prev_sclk = 1'b0; prev_cs = 1'b1;
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (word_id != seen_id) begin
         seen_id  = word_id;
         edge_n   = 0;
         samp_n   = 0;
         bad_iv   = 0;
         mosi_cap = '0;
      end
      if (tx_pop) begin
         pop_n   = pop_n + 1;
         pop_cyc = cyc;
      end
      if (busy && sclk !== prev_sclk) begin
         if (edge_n == 0) first_cyc = cyc;
         else if (cyc - last_edge_cyc != exp_h) bad_iv = bad_iv + 1;
         last_edge_cyc = cyc;
         if ((edge_n % 2) == cpha_m) begin
            mosi_cap = {mosi_cap[30:0], mosi};
            samp_n   = samp_n + 1;
         end
         edge_n = edge_n + 1;
      end
      if (rx_push) begin
         push_n   = push_n + 1;
         rx_last  = rx_data;
         push_cyc = cyc;
      end
      if (cs_n && !prev_cs) begin
         cs_rise_n   = cs_rise_n + 1;
         cs_rise_cyc = cyc;
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
   end

   initial begin
      #(CLK_P * 150000);
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_err = n_err + 1;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic cpol, input logic cpha, input logic loop,
                                      input logic [7:0] pre, input logic [7:0] post,
                                      input logic [4:0] lm1, input logic junk);
      logic [31:0] w;
      w        = '0;
      w[1]     = loop;
      w[2]     = cpol;
      w[3]     = cpha;
      w[11:4]  = pre;
      w[19:12] = post;
      w[24:20] = lm1;
      if (junk) begin
         w[0]     = 1'b1;
         w[25]    = 1'b1;
         w[31:26] = 6'h2B;
      end
      return w;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_idle(input int pushes);
      while (!(push_n >= pushes && cs_n)) @(negedge clk);
      tick(2);
   endtask

   task automatic run_word(input vec_t v, input logic junk, input logic do_mid,
                           input logic [31:0] mid_ctrl);
      logic [31:0] mask, exp_rx;
      int          p0;
      mask   = 32'((64'd1 << v.bits) - 64'd1);
      exp_rx = (v.loop ? v.tx : v.mi) & mask;
      ctrl     = mk(v.cpol, v.cpha, v.loop, v.pre, v.post, v.lm1, junk);
      exp_h    = int'(v.h);
      nbits    = int'(v.bits);
      cpha_m   = int'(v.cpha);
      miso_pat = v.mi;
      word_id  = word_id + 1;
      tick(3);
      p0 = push_n;
      txq[wr_n % 8] = v.tx;
      wr_n   = wr_n + 1;
      enable = 1'b1;
      if (do_mid) begin
         tick(5);
         ctrl = mid_ctrl;
      end
      wait_idle(p0 + 1);
      enable = 1'b0;
      chk("R3 first edge delay", first_cyc - pop_cyc, exp_h + 1);
      chk("R3 R4 half period", bad_iv, 0);
      chk("R5 edge count", edge_n, 2 * nbits);
      chk("R6 mosi bits", mosi_cap, v.tx & mask);
      chk(v.loop ? "R9 loopback data" : "R8 rx data", rx_last, exp_rx);
      chk("R8 push at final edge", push_cyc, last_edge_cyc);
      chk("R8 one push", push_n - p0, 1);
      chk("R11 cs rise", cs_rise_cyc, push_cyc + 1);
      chk("R7 idle level", sclk, v.cpol);
   endtask

   initial begin
      int p0, c0, q0;
      n_err = 0; n_chk = 0; wr_n = 0; word_id = 0;
      exp_h = 1; nbits = 0; cpha_m = 0; miso_pat = '0;
      rst_n = 1'b0; enable = 1'b0; ctrl = mk(1'b1, 1'b0, 1'b0, 8'd2, 8'd0, 5'd7, 1'b0);
      foreach (txq[i]) txq[i] = '0;
      tick(4);
      chk("R1 cs_n in reset", cs_n, 1);
      chk("R1 busy in reset", busy, 0);
      chk("R1 sclk in reset", sclk, 0);
      chk("R1 rx_push in reset", rx_push, 0);
      rst_n = 1'b1;
      tick(2);

      // table of vectors; odd entries fill the unused control bits (R2)
      for (int i = 0; i < 8; i++) run_word(VECS[i], logic'(i % 2), 1'b0, '0);

      // R13: control rewritten mid-word, same idle level
      run_word('{1'b0, 1'b0, 1'b0, 8'd2, 8'd0, 5'd7, 32'h0000_005A, 32'h0000_00C3, 8'd1, 6'd8},
               1'b0, 1'b1, mk(1'b0, 1'b1, 1'b1, 8'd10, 8'd3, 5'd15, 1'b0));
      chk("R13 data after mid change", rx_last, 32'h0000_00C3);

      // R10: enable low holds off a waiting word
      ctrl = mk(1'b0, 1'b0, 1'b1, 8'd2, 8'd0, 5'd7, 1'b0);
      nbits = 8; cpha_m = 0; exp_h = 1; word_id = word_id + 1;
      tick(2);
      q0 = pop_n; p0 = push_n;
      txq[wr_n % 8] = 32'h0000_0077;
      wr_n = wr_n + 1;
      tick(40);
      chk("R10 no pop while disabled", pop_n - q0, 0);
      chk("R10 cs_n high while disabled", cs_n, 1);
      enable = 1'b1;
      wait_idle(p0 + 1);
      enable = 1'b0;
      chk("R10 pop after enable", pop_n - q0, 1);
      chk("R10 fifo drained", rd_n, wr_n);
      chk("R9 data after enable", rx_last, 32'h0000_0077);

      // R11: three queued words form one burst under a single chip select
      word_id = word_id + 1;
      tick(2);
      q0 = pop_n; p0 = push_n; c0 = cs_rise_n;
      txq[wr_n % 8] = 32'h0000_0011; wr_n = wr_n + 1;
      txq[wr_n % 8] = 32'h0000_0022; wr_n = wr_n + 1;
      txq[wr_n % 8] = 32'h0000_013C; wr_n = wr_n + 1;
      enable = 1'b1;
      wait_idle(p0 + 3);
      enable = 1'b0;
      chk("R11 single cs release", cs_rise_n - c0, 1);
      chk("R10 pops in burst", pop_n - q0, 3);
      chk("R8 pushes in burst", push_n - p0, 3);
      chk("R6 R9 last burst word", rx_last, 32'h0000_003C);
      chk("R12 busy after burst", busy, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule